// File: doc/BRIEF.md
# Shared I/O Bus Arbiter

This block decides which of two internal engines owns a synchronous 16-bit peripheral bus. One engine performs programmed I/O and the other performs DMA. Both engines share the bus data lines, the device-select lines and the request-enable strobe. The block steers one engine's copy of these lines onto the bus. When neither engine holds the bus, it drives them to zero. Transfers on this bus are synchronous: peripherals return no handshake, and each engine reports through a done pulse when its operation has ended.

Peripherals ask for service on two request lines that every slot shares, one for DMA and one for interrupts. Each request type has its own serial priority chain from slot to slot. Slot 0 sits nearest the controller. A slot passes priority downstream only while it receives priority and is not requesting itself. The nearest requesting slot therefore wins each chain, and the two chains do not affect each other.

Ownership can change only while the bus is idle. An operation in progress always runs to its done pulse. When the bus is idle, a pending programmed-I/O request beats a DMA request that has not been acknowledged. Once a DMA request is acknowledged, it keeps the bus until its transfer completes.

Top module: `iobus_arb`

## Requirements
- R1: While reset is low and on the first cycle after it, both grants are low, the latched DMA slot is zero, and the bus data, select and enable outputs are zero.
- R2: The combined DMA request output is the OR of all slot DMA requests. The combined interrupt request output is the OR of all slot interrupt requests. Both follow their inputs in the same cycle.
- R3: Bit i of a chain's priority-out vector is high exactly when no slot with index 0 to i is requesting on that chain. With no requests, all bits are high.
- R4: A chain's winner vector is one-hot at the lowest-index requesting slot (bit 0 nearest the controller). It is all zero when no slot requests on that chain.
- R5: When the bus is idle and the programmed-I/O request is high at a clock edge, the programmed-I/O grant rises after that edge, even if a DMA request is pending.
- R6: When the bus is idle, the programmed-I/O request is low and any DMA request is high at an edge, the DMA grant rises after that edge. At the same edge the DMA winner is latched into the slot output, which then holds unchanged until the transfer completes.
- R7: A granted engine keeps its grant until its own done input is high at an edge. While a DMA transfer is in progress, a programmed-I/O request does not take the bus, and later DMA requests from nearer slots do not change the latched slot.
- R8: The two grants are never high together. The edge that samples a done input drops the grant, and at least one cycle with both grants low follows before either grant rises again. The latched slot clears at that same edge.
- R9: The bus data, select and enable outputs equal those of the granted engine. They are zero when no engine is granted.
- R10: The interrupt chain's winner and priority-out vectors depend only on the interrupt requests, whatever the DMA requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dma_req_i | input | NSLOT | Per-slot DMA request, bit 0 nearest the controller |
| irq_req_i | input | NSLOT | Per-slot interrupt request, bit 0 nearest the controller |
| pio_req_i | input | 1 | Programmed-I/O engine asks for the bus |
| pio_done_i | input | 1 | Programmed-I/O operation ends at this edge |
| dma_done_i | input | 1 | DMA transfer ends at this edge |
| pio_data_i | input | DW | Programmed-I/O engine data/address word |
| pio_sel_i | input | SEL_W | Programmed-I/O engine device select |
| pio_ren_i | input | 1 | Programmed-I/O engine request-enable |
| dma_data_i | input | DW | DMA engine data/address word |
| dma_sel_i | input | SEL_W | DMA engine device select |
| dma_ren_i | input | 1 | DMA engine request-enable |
| dma_line_o | output | 1 | Combined DMA request line |
| irq_line_o | output | 1 | Combined interrupt request line |
| dma_win_o | output | NSLOT | DMA chain winner, one-hot |
| irq_win_o | output | NSLOT | Interrupt chain winner, one-hot |
| dma_pass_o | output | NSLOT | DMA chain priority-out per slot |
| irq_pass_o | output | NSLOT | Interrupt chain priority-out per slot |
| pio_gnt_o | output | 1 | Programmed-I/O engine owns the bus |
| dma_gnt_o | output | 1 | DMA engine owns the bus (acknowledge) |
| dma_slot_o | output | NSLOT | Slot latched at DMA acknowledge, one-hot |
| bus_data_o | output | DW | Bus data/address lines |
| bus_sel_o | output | SEL_W | Bus device-select lines |
| bus_ren_o | output | 1 | Bus request-enable |

## Verification
A corrupted ownership state reaches the ports one cycle after the edge that stored it. Both grant outputs and the bus lines show it. A grant that drops without a done pulse, or two owners at once, changes the bus data word in that cycle. A slot register that reloads during a transfer shows on the slot output in the cycle after the disturbing request. Chain faults are combinational, so they appear in the same cycle as the request pattern that exposes them.

// File: rtl/iobus_arb_pkg.sv
package iobus_arb_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_PIO  = 2'd1,
      OWN_DMA  = 2'd2
   } own_e;
endpackage

// File: rtl/iobus_prio_chain.sv
module iobus_prio_chain #(
   parameter int NSLOT = 8
) (
   input  logic [NSLOT-1:0] req_i,
   output logic [NSLOT-1:0] win_o,
   output logic [NSLOT-1:0] pass_o,
   output logic             any_o
);
   logic [NSLOT:0] pri_in;

   assign pri_in[0] = 1'b1;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign win_o[s]    = pri_in[s] & req_i[s];
      assign pri_in[s+1] = pri_in[s] & ~req_i[s];
      assign pass_o[s]   = pri_in[s+1];
   end

   assign any_o = |req_i;
endmodule

// File: rtl/iobus_own_fsm.sv
module iobus_own_fsm
   import iobus_arb_pkg::*;
#(
   parameter int NSLOT = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pio_req_i,
   input  logic             pio_done_i,
   input  logic             dma_any_i,
   input  logic             dma_done_i,
   input  logic [NSLOT-1:0] dma_win_i,
   output own_e             own_o,
   output logic [NSLOT-1:0] slot_o
);
   own_e             own_q, own_d;
   logic [NSLOT-1:0] slot_q, slot_d;

   always_comb begin
      own_d  = own_q;
      slot_d = slot_q;
      unique case (own_q)
         OWN_IDLE: begin
            if (pio_req_i) begin
               own_d = OWN_PIO;
            end else if (dma_any_i) begin
               own_d  = OWN_DMA;
               slot_d = dma_win_i;
            end
         end
         OWN_PIO: begin
            if (pio_done_i) own_d = OWN_IDLE;
         end
         OWN_DMA: begin
            if (dma_done_i) begin
               own_d  = OWN_IDLE;
               slot_d = '0;
            end
         end
         default: begin
            own_d  = OWN_IDLE;
            slot_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         own_q  <= OWN_IDLE;
         slot_q <= '0;
      end else begin
         own_q  <= own_d;
         slot_q <= slot_d;
      end
   end

   assign own_o  = own_q;
   assign slot_o = slot_q;
endmodule

// File: rtl/iobus_bus_mux.sv
module iobus_bus_mux
   import iobus_arb_pkg::*;
#(
   parameter int DW    = 16,
   parameter int SEL_W = 6
) (
   input  own_e             own_i,
   input  logic [DW-1:0]    pio_data_i,
   input  logic [SEL_W-1:0] pio_sel_i,
   input  logic             pio_ren_i,
   input  logic [DW-1:0]    dma_data_i,
   input  logic [SEL_W-1:0] dma_sel_i,
   input  logic             dma_ren_i,
   output logic [DW-1:0]    bus_data_o,
   output logic [SEL_W-1:0] bus_sel_o,
   output logic             bus_ren_o
);
   always_comb begin
      bus_data_o = '0;
      bus_sel_o  = '0;
      bus_ren_o  = 1'b0;
      unique case (own_i)
         OWN_PIO: begin
            bus_data_o = pio_data_i;
            bus_sel_o  = pio_sel_i;
            bus_ren_o  = pio_ren_i;
         end
         OWN_DMA: begin
            bus_data_o = dma_data_i;
            bus_sel_o  = dma_sel_i;
            bus_ren_o  = dma_ren_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/iobus_arb.sv
module iobus_arb
   import iobus_arb_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int DW    = 16,
   parameter int SEL_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NSLOT-1:0] dma_req_i,
   input  logic [NSLOT-1:0] irq_req_i,
   input  logic             pio_req_i,
   input  logic             pio_done_i,
   input  logic             dma_done_i,
   input  logic [DW-1:0]    pio_data_i,
   input  logic [SEL_W-1:0] pio_sel_i,
   input  logic             pio_ren_i,
   input  logic [DW-1:0]    dma_data_i,
   input  logic [SEL_W-1:0] dma_sel_i,
   input  logic             dma_ren_i,
   output logic             dma_line_o,
   output logic             irq_line_o,
   output logic [NSLOT-1:0] dma_win_o,
   output logic [NSLOT-1:0] irq_win_o,
   output logic [NSLOT-1:0] dma_pass_o,
   output logic [NSLOT-1:0] irq_pass_o,
   output logic             pio_gnt_o,
   output logic             dma_gnt_o,
   output logic [NSLOT-1:0] dma_slot_o,
   output logic [DW-1:0]    bus_data_o,
   output logic [SEL_W-1:0] bus_sel_o,
   output logic             bus_ren_o
);
   localparam int NCHAIN = 2;

   if (NSLOT < 1) begin : g_bad_nslot
      $error("iobus_arb: NSLOT must be at least 1");
   end
   if (DW < 1 || SEL_W < 1) begin : g_bad_width
      $error("iobus_arb: DW and SEL_W must be at least 1");
   end

   logic [NCHAIN-1:0][NSLOT-1:0] chain_req, chain_win, chain_pass;
   logic [NCHAIN-1:0]            chain_any;
   own_e                         own;

   assign chain_req[0] = dma_req_i;
   assign chain_req[1] = irq_req_i;

   for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
      iobus_prio_chain #(.NSLOT(NSLOT)) u_chain (
         .req_i  (chain_req[c]),
         .win_o  (chain_win[c]),
         .pass_o (chain_pass[c]),
         .any_o  (chain_any[c])
      );
   end

   assign dma_win_o  = chain_win[0];
   assign irq_win_o  = chain_win[1];
   assign dma_pass_o = chain_pass[0];
   assign irq_pass_o = chain_pass[1];
   assign dma_line_o = chain_any[0];
   assign irq_line_o = chain_any[1];

   iobus_own_fsm #(.NSLOT(NSLOT)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pio_req_i  (pio_req_i),
      .pio_done_i (pio_done_i),
      .dma_any_i  (chain_any[0]),
      .dma_done_i (dma_done_i),
      .dma_win_i  (chain_win[0]),
      .own_o      (own),
      .slot_o     (dma_slot_o)
   );

   assign pio_gnt_o = (own == OWN_PIO);
   assign dma_gnt_o = (own == OWN_DMA);

   iobus_bus_mux #(.DW(DW), .SEL_W(SEL_W)) u_mux (
      .own_i      (own),
      .pio_data_i (pio_data_i),
      .pio_sel_i  (pio_sel_i),
      .pio_ren_i  (pio_ren_i),
      .dma_data_i (dma_data_i),
      .dma_sel_i  (dma_sel_i),
      .dma_ren_i  (dma_ren_i),
      .bus_data_o (bus_data_o),
      .bus_sel_o  (bus_sel_o),
      .bus_ren_o  (bus_ren_o)
   );
endmodule

// File: rtl/iobus_arb_chk.sv
module iobus_arb_chk #(
   parameter int NSLOT = 8,
   parameter int SEL_W = 6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             pio_req_i,
   input logic             pio_done_i,
   input logic             dma_done_i,
   input logic             pio_gnt_o,
   input logic             dma_gnt_o,
   input logic [NSLOT-1:0] dma_slot_o,
   input logic [NSLOT-1:0] dma_win_o,
   input logic [NSLOT-1:0] irq_win_o,
   input logic [SEL_W-1:0] bus_sel_o,
   input logic             bus_ren_o
);
   AST_GNT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pio_gnt_o && dma_gnt_o)); // R8

   AST_PIO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pio_gnt_o && !dma_gnt_o && pio_req_i) |=> pio_gnt_o); // R5

   AST_PIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pio_gnt_o && !pio_done_i) |=> pio_gnt_o); // R7

   AST_DMA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_gnt_o && !dma_done_i) |=> (dma_gnt_o && $stable(dma_slot_o))); // R7

   AST_DONE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pio_gnt_o && pio_done_i) || (dma_gnt_o && dma_done_i))
         |=> (!pio_gnt_o && !dma_gnt_o && dma_slot_o == '0)); // R8

   AST_SLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_gnt_o |-> $onehot(dma_slot_o)); // R6

   AST_WIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($onehot0(dma_win_o) && $onehot0(irq_win_o))); // R4

   AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pio_gnt_o && !dma_gnt_o) |-> (bus_sel_o == '0 && !bus_ren_o)); // R9
endmodule

bind iobus_arb iobus_arb_chk #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pio_req_i  (pio_req_i),
   .pio_done_i (pio_done_i),
   .dma_done_i (dma_done_i),
   .pio_gnt_o  (pio_gnt_o),
   .dma_gnt_o  (dma_gnt_o),
   .dma_slot_o (dma_slot_o),
   .dma_win_o  (dma_win_o),
   .irq_win_o  (irq_win_o),
   .bus_sel_o  (bus_sel_o),
   .bus_ren_o  (bus_ren_o)
);

// File: tb/iobus_arb_tb.sv
`timescale 1ns/1ps
module iobus_arb_tb;
   localparam int NSLOT = 8;
   localparam int DW    = 16;
   localparam int SEL_W = 6;
   localparam logic [DW-1:0]    PDATA = 16'hA5A5;
   localparam logic [DW-1:0]    DDATA = 16'h3C3C;
   localparam logic [SEL_W-1:0] PSEL  = 6'h11;
   localparam logic [SEL_W-1:0] DSEL  = 6'h2A;

   typedef struct {
      logic             pio;
      logic             dma;
      logic [NSLOT-1:0] slot;
      string            tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSLOT-1:0] dma_req = '0, irq_req = '0;
   logic pio_req = 1'b0, pio_done = 1'b0, dma_done = 1'b0;
   logic dma_line, irq_line, pio_gnt, dma_gnt, bus_ren;
   logic [NSLOT-1:0] dma_win, irq_win, dma_pass, irq_pass, dma_slot;
   logic [DW-1:0] bus_data;
   logic [SEL_W-1:0] bus_sel;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   iobus_arb #(.NSLOT(NSLOT), .DW(DW), .SEL_W(SEL_W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .dma_req_i(dma_req), .irq_req_i(irq_req),
      .pio_req_i(pio_req), .pio_done_i(pio_done), .dma_done_i(dma_done),
      .pio_data_i(PDATA), .pio_sel_i(PSEL), .pio_ren_i(1'b1),
      .dma_data_i(DDATA), .dma_sel_i(DSEL), .dma_ren_i(1'b1),
      .dma_line_o(dma_line), .irq_line_o(irq_line),
      .dma_win_o(dma_win), .irq_win_o(irq_win),
      .dma_pass_o(dma_pass), .irq_pass_o(irq_pass),
      .pio_gnt_o(pio_gnt), .dma_gnt_o(dma_gnt), .dma_slot_o(dma_slot),
      .bus_data_o(bus_data), .bus_sel_o(bus_sel), .bus_ren_o(bus_ren)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compare registered outputs shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            logic [DW-1:0] ed;
            logic [SEL_W-1:0] es;
            e = exp_q.pop_front();
            ed = e.pio ? PDATA : (e.dma ? DDATA : '0);
            es = e.pio ? PSEL : (e.dma ? DSEL : '0);
            chk({e.tag, " pio_gnt"}, 32'(pio_gnt), 32'(e.pio));
            chk({e.tag, " dma_gnt"}, 32'(dma_gnt), 32'(e.dma));
            chk({e.tag, " dma_slot"}, 32'(dma_slot), 32'(e.slot));
            chk("R9 bus_data", 32'(bus_data), 32'(ed));
            chk("R9 bus_sel", 32'(bus_sel), 32'(es));
            chk("R9 bus_ren", 32'(bus_ren), 32'(e.pio | e.dma));
         end
      end
   end

   // driver: apply inputs at the falling edge, queue the result due after the next rise
   task automatic step(input logic preq, input logic pdone, input logic ddone,
                       input logic [NSLOT-1:0] dreq,
                       input logic ep, input logic ed, input logic [NSLOT-1:0] es,
                       input string tag);
      exp_t e;
      @(negedge clk);
      pio_req = preq; pio_done = pdone; dma_done = ddone; dma_req = dreq;
      e.pio = ep; e.dma = ed; e.slot = es; e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pio_gnt", 32'(pio_gnt), 0);
      chk("R1 dma_gnt", 32'(dma_gnt), 0);
      chk("R1 bus_data", 32'(bus_data), 0);
      chk("R1 dma_slot", 32'(dma_slot), 0);
      rst_n = 1'b1;

      // R2 R3 R4: no requests
      #0.5;
      chk("R2 dma_line idle", 32'(dma_line), 0);
      chk("R2 irq_line idle", 32'(irq_line), 0);
      chk("R3 dma_pass idle", 32'(dma_pass), 32'hFF);
      chk("R4 dma_win idle", 32'(dma_win), 0);

      step(0, 0, 0, 8'h00, 0, 0, 8'h00, "R1");
      // R5: PIO beats an unacknowledged DMA request
      step(1, 0, 0, 8'b0010_0100, 1, 0, 8'h00, "R5");
      #0.5;
      chk("R2 dma_line", 32'(dma_line), 1);
      chk("R3 dma_pass", 32'(dma_pass), 32'b0000_0011);
      chk("R4 dma_win", 32'(dma_win), 32'b0000_0100);
      // R10: interrupt chain independent of DMA chain
      irq_req = 8'b0110_0000;
      #0.5;
      chk("R10 irq_win", 32'(irq_win), 32'b0010_0000);
      chk("R10 irq_pass", 32'(irq_pass), 32'b0001_1111);
      chk("R2 irq_line", 32'(irq_line), 1);
      chk("R10 dma_win unchanged", 32'(dma_win), 32'b0000_0100);
      step(0, 0, 0, 8'b0010_0100, 1, 0, 8'h00, "R7 pio hold");
      irq_req = 8'b0000_0001;
      #0.5;
      chk("R10 irq_win slot0", 32'(irq_win), 32'b0000_0001);
      chk("R10 irq_pass slot0", 32'(irq_pass), 32'h00);
      chk("R10 dma_pass unchanged", 32'(dma_pass), 32'b0000_0011);
      irq_req = '0;
      step(0, 1, 0, 8'b0010_0100, 0, 0, 8'h00, "R8 pio done gap");
      step(0, 0, 0, 8'b0010_0100, 0, 1, 8'b0000_0100, "R6 dma ack");
      step(1, 0, 0, 8'b0000_0001, 0, 1, 8'b0000_0100, "R7 dma hold");
      step(1, 1, 0, 8'b0000_0001, 0, 1, 8'b0000_0100, "R7 foreign done");
      step(0, 0, 1, 8'b0000_0001, 0, 0, 8'h00, "R8 dma done gap");
      step(1, 0, 0, 8'b0000_0001, 1, 0, 8'h00, "R5 again");
      step(0, 1, 0, 8'h00, 0, 0, 8'h00, "R8 pio done");
      step(0, 0, 0, 8'b1000_0000, 0, 1, 8'b1000_0000, "R6 far slot");
      #0.5;
      chk("R3 dma_pass far", 32'(dma_pass), 32'b0111_1111);
      step(0, 0, 1, 8'h00, 0, 0, 8'h00, "R8 dma done");
      step(0, 0, 0, 8'h00, 0, 0, 8'h00, "R8 idle");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule